// File: doc/BRIEF.md
# Serial Frequency-Synthesizer Parameter Loader

This block collects the settings of a frequency synthesizer that software delivers one bit per register write. Each write carries a serial data bit and a load strobe. The block counts the bits from reset or from the last strobe. It captures the bits that fall inside the parameter fields into a shadow store and discards the padding bits between the fields.

When the strobe arrives on the last bit of a frame and every field holds a legal value, the block copies the assembled parameters to its static output registers and raises an update pulse for one clock. A strobe at any other bit count, or a frame with an illegal field, sets a sticky error flag and leaves the outputs unchanged. The outputs are a post-divider select, a frequency-range select, a feedback multiplier, an additive term and a reference divider. They feed a synthesizer that lies outside this block.

Top module: `pll_serial_loader`

## Requirements
- R1: After reset the outputs are post-divider code 0, range code 0, multiplier 34, additive term 1, reference divider 29. The update pulse and the error flag are low.
- R2: A write is a cycle with `wr_en_i` high. `wr_data_i[0]` is the serial bit and `wr_data_i[1]` is the strobe. A frame is 56 writes, indexed from 0. The post-divider code is at indices 12..13, the range code at 24..25, the multiplier at 32..39, the additive term at 40..47 and the reference divider at 48..55. Every field is sent least significant bit first. The bits at all other indices have no effect on the outputs.
- R3: A strobe on write index 55 with legal fields loads all five outputs. In the following cycle `update_o` is high for exactly one clock.
- R4: A strobe on any write index other than 55 sets `err_o`, does not raise `update_o` and leaves the outputs unchanged.
- R5: `err_o` stays high once set, including across later valid commits, until reset.
- R6: The post-divider code must be 0, 1 or 2, meaning divide by 1, 2 or 4. Code 3 rejects the commit: error set, outputs unchanged.
- R7: The first range bit sent becomes bit 0 of the range code. The sequence 0,0 gives code 0 (up to 120 MHz), 1,0 gives code 1 (up to 200 MHz) and 0,1 gives code 2 (above 200 MHz). Code 3 rejects the commit.
- R8: A multiplier above 63 rejects the commit.
- R9: Cycles with `wr_en_i` low are ignored, even when `wr_data_i[1]` is high. The outputs change only on an update.
- R10: Every strobe restarts the bit count at index 0, whether its commit is accepted or rejected, so the next full frame can commit.
- R11: After 56 writes without a strobe the count stays at 56. Any later strobe is then rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write valid |
| wr_data_i | input | 2 | Bit 0 serial data, bit 1 load strobe |
| shift_o | output | 2 | Post-divider code (0,1,2 = divide 1,2,4) |
| range_o | output | 2 | Frequency-range code |
| mult_o | output | 8 | Feedback multiplier |
| add_o | output | 8 | Additive term |
| rdiv_o | output | 8 | Reference divider |
| update_o | output | 1 | One-clock pulse after an accepted commit |
| err_o | output | 1 | Sticky framing or field error |

## Verification
The bench sends frames whose padding bits are all ones and then all zeros. A design that let padding bits leak into a field would load wrong values. A strobe at index 30 must be rejected; a design that committed on any strobe would corrupt the outputs there. The bench then sends a valid frame straight afterwards, which exposes a counter that does not restart. Separate frames carry multiplier 64, post-divider code 3 and range code 3, and one stream of 57 writes overruns the frame. A design missing the matching check would update in those cases. The multiplier boundary value 63 must still be accepted. Gapped writes with a stray strobe while `wr_en_i` is low expose a design that samples the strobe without the write enable.

// File: rtl/pll_loader_pkg.sv
package pll_loader_pkg;

    // Field widths of the serial frame
    localparam int LEAD_BITS  = 12;
    localparam int SHIFT_BITS = 2;
    localparam int GAP_BITS   = 10;
    localparam int RANGE_BITS = 2;
    localparam int PAD_BITS   = 6;
    localparam int FIELD_BITS = 8;

    // Derived bit positions within the frame
    localparam int SHIFT_POS  = LEAD_BITS;
    localparam int RANGE_POS  = SHIFT_POS + SHIFT_BITS + GAP_BITS;
    localparam int MULT_POS   = RANGE_POS + RANGE_BITS + PAD_BITS;
    localparam int ADD_POS    = MULT_POS + FIELD_BITS;
    localparam int RDIV_POS   = ADD_POS + FIELD_BITS;
    localparam int FRAME_BITS = RDIV_POS + FIELD_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Legal limits and reset values
    localparam int MULT_MAX   = 63;
    localparam int SHIFT_MAX  = 2;
    localparam int RANGE_MAX  = 2;
    localparam int DEF_MULT   = 34;
    localparam int DEF_ADD    = 1;
    localparam int DEF_RDIV   = 29;

    typedef struct packed {
        logic [SHIFT_BITS-1:0] shift;
        logic [RANGE_BITS-1:0] range;
        logic [FIELD_BITS-1:0] mult;
        logic [FIELD_BITS-1:0] add;
        logic [FIELD_BITS-1:0] rdiv;
    } pll_params_t;

    localparam pll_params_t PARAMS_RESET = '{
        shift: '0,
        range: '0,
        mult:  FIELD_BITS'(DEF_MULT),
        add:   FIELD_BITS'(DEF_ADD),
        rdiv:  FIELD_BITS'(DEF_RDIV)
    };

endpackage

// File: rtl/pll_bit_counter.sv
module pll_bit_counter
    import pll_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             strobe_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_last_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (wr_en_i) begin
            if (strobe_i) begin
                count_d = '0;
            end else if (count_q != CNT_FULL) begin
                count_d = count_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count_o   = count_q;
    assign at_last_o = (count_q == CNT_LAST);

endmodule

// File: rtl/pll_field_shadow.sv
module pll_field_shadow
    import pll_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] count_i,
    output pll_params_t      live_o
);

    pll_params_t fields_d, fields_q;

    // Each field bit is captured only on its own index; padding is dropped.
    always_comb begin
        fields_d = fields_q;
        if (wr_en_i) begin
            for (int i = 0; i < SHIFT_BITS; i++) begin
                if (count_i == CNT_W'(SHIFT_POS + i)) fields_d.shift[i] = bit_i;
            end
            for (int i = 0; i < RANGE_BITS; i++) begin
                if (count_i == CNT_W'(RANGE_POS + i)) fields_d.range[i] = bit_i;
            end
            for (int i = 0; i < FIELD_BITS; i++) begin
                if (count_i == CNT_W'(MULT_POS + i)) fields_d.mult[i] = bit_i;
                if (count_i == CNT_W'(ADD_POS + i))  fields_d.add[i]  = bit_i;
                if (count_i == CNT_W'(RDIV_POS + i)) fields_d.rdiv[i] = bit_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
        end else begin
            fields_q <= fields_d;
        end
    end

    // The next value already holds the bit of the current write.
    assign live_o = fields_d;

endmodule

// File: rtl/pll_field_check.sv
module pll_field_check
    import pll_loader_pkg::*;
(
    input  logic [SHIFT_BITS-1:0] shift_i,
    input  logic [RANGE_BITS-1:0] range_i,
    input  logic [FIELD_BITS-1:0] mult_i,
    output logic                  legal_o
);

    logic shift_ok, range_ok, mult_ok;

    always_comb begin
        shift_ok = (shift_i <= SHIFT_BITS'(SHIFT_MAX));
        range_ok = (range_i <= RANGE_BITS'(RANGE_MAX));
        mult_ok  = (mult_i  <= FIELD_BITS'(MULT_MAX));
        legal_o  = shift_ok && range_ok && mult_ok;
    end

endmodule

// File: rtl/pll_serial_loader.sv
module pll_serial_loader
    import pll_loader_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_data_i,
    output logic [1:0] shift_o,
    output logic [1:0] range_o,
    output logic [7:0] mult_o,
    output logic [7:0] add_o,
    output logic [7:0] rdiv_o,
    output logic       update_o,
    output logic       err_o
);

    typedef struct packed {
        pll_params_t params;
        logic        update;
        logic        err;
    } loader_state_t;

    logic             data_bit;
    logic             strobe;
    logic [CNT_W-1:0] bit_count;
    logic             at_last;
    pll_params_t      live;
    logic             fields_legal;
    logic             commit_ok;
    logic             commit_bad;

    loader_state_t st_d, st_q;

    assign data_bit = wr_data_i[0];
    assign strobe   = wr_data_i[1];

    pll_bit_counter u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .strobe_i  (strobe),
        .count_o   (bit_count),
        .at_last_o (at_last)
    );

    pll_field_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .bit_i   (data_bit),
        .count_i (bit_count),
        .live_o  (live)
    );

    pll_field_check u_check (
        .shift_i (live.shift),
        .range_i (live.range),
        .mult_i  (live.mult),
        .legal_o (fields_legal)
    );

    always_comb begin
        commit_ok  = wr_en_i && strobe && at_last && fields_legal;
        commit_bad = wr_en_i && strobe && !commit_ok;

        st_d        = st_q;
        st_d.update = 1'b0;
        if (commit_ok) begin
            st_d.params = live;
            st_d.update = 1'b1;
        end
        if (commit_bad) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.params <= PARAMS_RESET;
            st_q.update <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o  = st_q.params.shift;
    assign range_o  = st_q.params.range;
    assign mult_o   = st_q.params.mult;
    assign add_o    = st_q.params.add;
    assign rdiv_o   = st_q.params.rdiv;
    assign update_o = st_q.update;
    assign err_o    = st_q.err;

endmodule

// File: rtl/pll_serial_loader_sva.sv
module pll_serial_loader_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [1:0] wr_data_i,
    input logic [1:0] shift_o,
    input logic [1:0] range_o,
    input logic [7:0] mult_o,
    input logic [7:0] add_o,
    input logic [7:0] rdiv_o,
    input logic       update_o,
    input logic       err_o
);

    assert_pulse_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    assert_update_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> $past(wr_en_i && wr_data_i[1]));

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> $stable({shift_o, range_o, mult_o, add_o, rdiv_o}));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    assert_shift_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o != 2'd3);

    assert_range_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_o != 2'd3);

    assert_mult_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mult_o <= 8'd63);

endmodule

bind pll_serial_loader pll_serial_loader_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .shift_o   (shift_o),
    .range_o   (range_o),
    .mult_o    (mult_o),
    .add_o     (add_o),
    .rdiv_o    (rdiv_o),
    .update_o  (update_o),
    .err_o     (err_o)
);

// File: tb/sim_pll_serial_loader.sv
`timescale 1ns/1ps
module sim_pll_serial_loader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_data_i = 2'b00;
    logic [1:0] shift_o, range_o;
    logic [7:0] mult_o, add_o, rdiv_o;
    logic       update_o, err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pll_serial_loader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .shift_o   (shift_o),
        .range_o   (range_o),
        .mult_o    (mult_o),
        .add_o     (add_o),
        .rdiv_o    (rdiv_o),
        .update_o  (update_o),
        .err_o     (err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input int sh, input int rg,
                            input int m, input int a, input int r);
        chk(req, "shift", shift_o, sh);
        chk(req, "range", range_o, rg);
        chk(req, "mult",  mult_o,  m);
        chk(req, "add",   add_o,   a);
        chk(req, "rdiv",  rdiv_o,  r);
    endtask

    // Frame layout per R2; padding bits all equal to fill.
    function automatic logic [55:0] build(input int sh, input int rg, input int m,
                                          input int a, input int r, input bit fill);
        logic [55:0] f;
        f = {56{fill}};
        for (int i = 0; i < 2; i++) f[12 + i] = sh[i];
        for (int i = 0; i < 2; i++) f[24 + i] = rg[i];
        for (int i = 0; i < 8; i++) begin
            f[32 + i] = m[i];
            f[40 + i] = a[i];
            f[48 + i] = r[i];
        end
        return f;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One write, driven at a falling edge; returns at the next falling edge.
    task automatic wr(input bit d, input bit s);
        wr_en_i   = 1'b1;
        wr_data_i = {s, d};
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = 2'b00;
    endtask

    // Sends bits 0..n-1; strobe on the last one if strobe_last.
    task automatic send(input logic [55:0] f, input int n, input bit strobe_last, input bit gapped);
        for (int i = 0; i < n; i++) begin
            wr(f[i % 56], strobe_last && (i == n - 1));
            if (gapped && i != n - 1) begin
                wr_data_i = 2'b10;
                @(negedge clk);
                wr_data_i = 2'b00;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk_outs("R1", 0, 0, 34, 1, 29);
        chk("R1", "update", update_o, 0);
        chk("R1", "err", err_o, 0);
    endtask

    task automatic t_valid_fill1();
        send(build(1, 1, 8'h2a, 8'h05, 8'h7f, 1'b1), 56, 1'b1, 1'b0);
        chk("R3", "update pulse", update_o, 1);
        chk_outs("R2", 1, 1, 8'h2a, 8'h05, 8'h7f);
        @(negedge clk);
        chk("R3", "update one cycle", update_o, 0);
        chk("R3", "err", err_o, 0);
    endtask

    task automatic t_valid_fill0();
        send(build(2, 2, 63, 8'hff, 0, 1'b0), 56, 1'b1, 1'b0);
        chk("R8", "mult 63 accepted", update_o, 1);
        chk_outs("R7", 2, 2, 63, 255, 0);
        @(negedge clk);
    endtask

    task automatic t_gapped();
        send(build(0, 0, 17, 200, 3, 1'b1), 56, 1'b1, 1'b1);
        chk("R9", "gapped update", update_o, 1);
        chk_outs("R9", 0, 0, 17, 200, 3);
        chk("R9", "stray strobe ignored", err_o, 0);
        @(negedge clk);
        chk_outs("R9", 0, 0, 17, 200, 3);
    endtask

    task automatic t_early_strobe();
        send(build(1, 0, 5, 6, 7, 1'b0), 31, 1'b1, 1'b0);
        chk("R4", "no update", update_o, 0);
        chk("R4", "err set", err_o, 1);
        chk_outs("R4", 0, 0, 17, 200, 3);
        send(build(1, 0, 5, 6, 7, 1'b0), 56, 1'b1, 1'b0);
        chk("R10", "restart commit", update_o, 1);
        chk_outs("R10", 1, 0, 5, 6, 7);
        chk("R5", "err sticky", err_o, 1);
        @(negedge clk);
    endtask

    task automatic t_bad_mult();
        do_reset();
        send(build(0, 1, 64, 9, 9, 1'b0), 56, 1'b1, 1'b0);
        chk("R8", "no update", update_o, 0);
        chk("R8", "err", err_o, 1);
        chk_outs("R8", 0, 0, 34, 1, 29);
    endtask

    task automatic t_bad_shift();
        do_reset();
        send(build(3, 0, 10, 9, 9, 1'b0), 56, 1'b1, 1'b0);
        chk("R6", "no update", update_o, 0);
        chk("R6", "err", err_o, 1);
        chk_outs("R6", 0, 0, 34, 1, 29);
    endtask

    task automatic t_bad_range();
        do_reset();
        send(build(1, 3, 10, 9, 9, 1'b1), 56, 1'b1, 1'b0);
        chk("R7", "no update", update_o, 0);
        chk("R7", "err", err_o, 1);
        chk_outs("R7", 0, 0, 34, 1, 29);
    endtask

    task automatic t_overrun();
        do_reset();
        send(build(1, 1, 40, 41, 42, 1'b0), 57, 1'b1, 1'b0);
        chk("R11", "no update", update_o, 0);
        chk("R11", "err", err_o, 1);
        chk_outs("R11", 0, 0, 34, 1, 29);
        send(build(1, 1, 40, 41, 42, 1'b0), 56, 1'b1, 1'b0);
        chk("R10", "commit after overrun", update_o, 1);
        chk_outs("R10", 1, 1, 40, 41, 42);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_valid_fill1();
        t_valid_fill0();
        t_gapped();
        t_early_strobe();
        t_bad_mult();
        t_bad_shift();
        t_bad_range();
        t_overrun();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule